// File: doc/BRIEF.md
# Wake-on-Press Matrix Keypad Scanner

This block serves a 4×4 key matrix while staying quiet until someone presses a key. At rest it holds every column line low and watches the row lines, which idle high through pull-ups. When any row drops, the block raises an active-low wake request, waits out a debounce interval, and only then walks the columns one at a time to find which key is down.

A clean single press gives a 4-bit key number together with a one-cycle strobe. The block then waits for the matrix to be fully released before it arms the detector again. A short blip is dropped without output. So is any pattern that involves more than one row or more than one column.

The debounce length is given in clock cycles, derived from the clock frequency and a millisecond figure. A short override is provided for simulation.

Top module: `keypad_scan_top`

## Requirements
- R1: While the block is idle or waiting for release (wake request high), every column output is driven to 0. After reset, `irq_n` is 1 and `key_valid` is 0.
- R2: A row input that goes low while the block is idle pulls `irq_n` low within 3 clock cycles: two synchroniser stages plus one state register.
- R3: No key code is delivered earlier than the debounce interval (DB cycles) after the press reaches the row inputs.
- R4: During the column walk, exactly one column output is 0 and the others are 1. Columns are visited in order 0 to 3.
- R5: For a single pressed key at row r and column c, `key_code` equals r*4 + c, where row and column are the bit indices of `row_in` and `col_out`. `key_valid` is high for exactly one cycle, and `irq_n` returns high on the cycle that `key_valid` rises.
- R6: If all rows read high again when the debounce interval ends, no code is produced and `irq_n` returns high.
- R7: A press involving two or more rows, or two or more columns, produces no code and releases `irq_n`.
- R8: After a code is delivered, the detector re-arms only once all rows have read high for DB consecutive cycles. A held or re-bounced key therefore yields exactly one code.
- R9: Synchronous reset (`rst` high) returns the block to idle from any state: columns at 0, `irq_n` at 1, no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_in | input | 4 | Row sense lines, pulled up, low when a key connects them to a low column |
| col_out | output | 4 | Column drive lines |
| irq_n | output | 1 | Active-low wake/interrupt request |
| key_valid | output | 1 | One-cycle strobe marking a new key code |
| key_code | output | 4 | Binary key number, row*4 + column |

## Verification
The checker watches properties that hold on every cycle:
- the column bus carries either all zeros or exactly one zero;
- the columns rest at zero whenever the wake request is inactive;
- a wake event is followed by the request on the next cycle;
- the strobe lasts a single cycle, comes only after the request was active, and is absent right after reset.

Only the bench scenarios can show the following:
- the mapping from key position to code;
- the debounce latency;
- the rejection of blips and multi-key patterns;
- the rule that a held or bouncing key is reported once.

These need a modelled matrix and a view across many cycles.

// File: rtl/keypad_pkg.sv
package keypad_pkg;

  typedef enum logic [1:0] {
    ST_IDLE     = 2'd0,
    ST_DEBOUNCE = 2'd1,
    ST_SCAN     = 2'd2,
    ST_RELEASE  = 2'd3
  } scan_state_t;

  // Linear key number from a row and a column index.
  function automatic int key_number(input int row, input int col, input int ncols);
    return row * ncols + col;
  endfunction

endpackage

// File: rtl/keypad_sync.sv
module keypad_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          stage[s] <= '1;
        end else begin
          stage[s] <= (s == 0) ? d : stage[(s == 0) ? 0 : s - 1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];

endmodule

// File: rtl/keypad_timer.sv
module keypad_timer #(
  parameter int LIMIT = 5_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic done
);

  localparam int CNT_W = $clog2(LIMIT + 1);

  logic [CNT_W-1:0] cnt;

  assign done = (cnt == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt <= '0;
    end else if (!done) begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/keypad_ctrl.sv
module keypad_ctrl
  import keypad_pkg::*;
#(
  parameter int NUM_ROWS      = 4,
  parameter int NUM_COLS      = 4,
  parameter int SETTLE_CYCLES = 2,
  parameter int CODE_W        = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] rows_s,
  input  logic                tmr_done,
  output logic                tmr_restart,
  output logic [NUM_COLS-1:0] col_drive,
  output logic                irq_n,
  output logic                key_valid,
  output logic [CODE_W-1:0]   key_code,
  output logic                wake_evt
);

  localparam int RIDX_W = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
  localparam int CIDX_W = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
  localparam int SET_W  = $clog2(SETTLE_CYCLES + 1);

  scan_state_t         state;
  logic [CIDX_W-1:0]   col_idx;
  logic [SET_W-1:0]    settle_cnt;
  logic [NUM_ROWS-1:0] row_pat;
  logic [NUM_COLS-1:0] hit_cols;
  logic                bad;
  logic                rel_first;

  logic                any_low;
  logic                single_row;
  logic                sample_now;
  logic                last_col;
  logic [NUM_COLS-1:0] hit_next;
  logic                bad_next;

  function automatic logic [RIDX_W-1:0] first_low(input logic [NUM_ROWS-1:0] v);
    logic [RIDX_W-1:0] idx = '0;
    for (int i = NUM_ROWS - 1; i >= 0; i--) begin
      if (!v[i]) idx = RIDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [CIDX_W-1:0] first_high(input logic [NUM_COLS-1:0] v);
    logic [CIDX_W-1:0] idx = '0;
    for (int i = NUM_COLS - 1; i >= 0; i--) begin
      if (v[i]) idx = CIDX_W'(i);
    end
    return idx;
  endfunction

  function automatic logic [NUM_COLS-1:0] col_pattern(input logic [CIDX_W-1:0] idx);
    logic [NUM_COLS-1:0] p = '1;
    p[idx] = 1'b0;
    return p;
  endfunction

  assign any_low    = ~&rows_s;
  assign single_row = ($countones(~rows_s) == 1);
  assign sample_now = (settle_cnt == SET_W'(SETTLE_CYCLES));
  assign last_col   = (col_idx == CIDX_W'(NUM_COLS - 1));
  assign wake_evt   = (state == ST_IDLE) && any_low;
  assign irq_n      = !((state == ST_DEBOUNCE) || (state == ST_SCAN));

  assign tmr_restart = (state == ST_IDLE) || (state == ST_SCAN) ||
                       ((state == ST_RELEASE) && (any_low || rel_first));

  always_comb begin
    hit_next = hit_cols;
    if (any_low) hit_next[col_idx] = 1'b1;
    bad_next = bad || (any_low && (rows_s != row_pat));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      col_idx    <= '0;
      settle_cnt <= '0;
      row_pat    <= '1;
      hit_cols   <= '0;
      bad        <= 1'b0;
      rel_first  <= 1'b0;
      col_drive  <= '0;
      key_valid  <= 1'b0;
      key_code   <= '0;
    end else begin
      key_valid <= 1'b0;
      rel_first <= 1'b0;
      case (state)
        ST_IDLE: begin
          col_drive <= '0;
          if (any_low) state <= ST_DEBOUNCE;
        end
        ST_DEBOUNCE: begin
          if (tmr_done) begin
            if (!any_low) begin
              state <= ST_IDLE;
            end else if (single_row) begin
              state      <= ST_SCAN;
              row_pat    <= rows_s;
              col_idx    <= '0;
              settle_cnt <= '0;
              hit_cols   <= '0;
              bad        <= 1'b0;
              col_drive  <= col_pattern('0);
            end else begin
              state     <= ST_RELEASE;
              rel_first <= 1'b1;
            end
          end
        end
        ST_SCAN: begin
          if (sample_now) begin
            hit_cols   <= hit_next;
            bad        <= bad_next;
            settle_cnt <= '0;
            if (last_col) begin
              state     <= ST_RELEASE;
              rel_first <= 1'b1;
              col_drive <= '0;
              if (!bad_next && ($countones(hit_next) == 1)) begin
                key_valid <= 1'b1;
                key_code  <= CODE_W'(key_number(int'(first_low(row_pat)),
                                                int'(first_high(hit_next)), NUM_COLS));
              end
            end else begin
              col_idx   <= col_idx + 1'b1;
              col_drive <= col_pattern(col_idx + 1'b1);
            end
          end else begin
            settle_cnt <= settle_cnt + 1'b1;
          end
        end
        ST_RELEASE: begin
          col_drive <= '0;
          if (tmr_done && !rel_first && !any_low) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/keypad_scan_top.sv
module keypad_scan_top #(
  parameter int NUM_ROWS            = 4,
  parameter int NUM_COLS            = 4,
  parameter int CLK_HZ              = 250_000_000,
  parameter int DEBOUNCE_MS         = 20,
  parameter int SIM_DEBOUNCE_CYCLES = 0,
  parameter int SYNC_STAGES         = 2,
  localparam int CODE_W             = $clog2(NUM_ROWS * NUM_COLS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_ROWS-1:0] row_in,
  output logic [NUM_COLS-1:0] col_out,
  output logic                irq_n,
  output logic                key_valid,
  output logic [CODE_W-1:0]   key_code
);

  localparam int DB_DERIVED = (CLK_HZ / 1000) * DEBOUNCE_MS;
  localparam int DB_CYCLES  = (SIM_DEBOUNCE_CYCLES > 0) ? SIM_DEBOUNCE_CYCLES : DB_DERIVED;

  logic [NUM_ROWS-1:0] rows_s;
  logic                tmr_restart;
  logic                tmr_done;
  logic                wake_evt;

  keypad_sync #(.WIDTH(NUM_ROWS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (row_in),
    .q   (rows_s)
  );

  keypad_timer #(.LIMIT(DB_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (tmr_restart),
    .done    (tmr_done)
  );

  keypad_ctrl #(
    .NUM_ROWS      (NUM_ROWS),
    .NUM_COLS      (NUM_COLS),
    .SETTLE_CYCLES (SYNC_STAGES),
    .CODE_W        (CODE_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rows_s      (rows_s),
    .tmr_done    (tmr_done),
    .tmr_restart (tmr_restart),
    .col_drive   (col_out),
    .irq_n       (irq_n),
    .key_valid   (key_valid),
    .key_code    (key_code),
    .wake_evt    (wake_evt)
  );

endmodule

// File: rtl/keypad_scan_chk.sv
module keypad_scan_chk #(
  parameter int NUM_COLS = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [NUM_COLS-1:0] col_out,
  input logic                irq_n,
  input logic                key_valid,
  input logic                wake_evt
);

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1
  cols_low_at_rest_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n |-> (col_out == '0));

  // R4
  one_col_driven_chk: assert property (@(posedge clk) disable iff (rst)
    (col_out != '0) |-> ($countones(col_out) == NUM_COLS - 1));

  // R2
  wake_raises_irq_chk: assert property (@(posedge clk) disable iff (rst)
    wake_evt |=> !irq_n);

  // R5
  strobe_single_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |=> !key_valid);

  // R5
  strobe_after_irq_chk: assert property (@(posedge clk) disable iff (rst)
    key_valid |-> (irq_n && !$past(irq_n)));

  // R9
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> ((col_out == '0) && irq_n && !key_valid));

endmodule

bind keypad_scan_top keypad_scan_chk #(.NUM_COLS(NUM_COLS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .col_out   (col_out),
  .irq_n     (irq_n),
  .key_valid (key_valid),
  .wake_evt  (wake_evt)
);

// File: tb/tb_keypad_scan_top.sv
module tb_keypad_scan_top;

  localparam int DB = 40;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] row_in;
  logic [3:0] col_out;
  logic       irq_n;
  logic       key_valid;
  logic [3:0] key_code;
  logic [15:0] pressed = '0;

  int n_checks = 0;
  int n_bad    = 0;
  int valid_cnt = 0;
  logic [3:0] last_code = '0;
  bit irq_seen = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  keypad_scan_top #(.SIM_DEBOUNCE_CYCLES(DB)) dut (
    .clk(clk), .rst(rst), .row_in(row_in), .col_out(col_out),
    .irq_n(irq_n), .key_valid(key_valid), .key_code(key_code)
  );

  // Matrix model: a row reads low when a pressed key joins it to a low column.
  always_comb begin
    for (int r = 0; r < 4; r++) begin
      row_in[r] = 1'b1;
      for (int c = 0; c < 4; c++)
        if (pressed[r*4+c] && !col_out[c]) row_in[r] = 1'b0;
    end
  end

  always @(negedge clk) begin
    if (key_valid) begin valid_cnt++; last_code = key_code; end
    if (!irq_n) irq_seen = 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rearm();
    pressed = '0;
    tick(DB + 20);
  endtask

  // R2 R3 R5: single key press, code, latency
  task automatic test_single(input int r, input int c);
    int v0, lat, irq_lat;
    v0 = valid_cnt; lat = 0; irq_lat = -1;
    pressed[r*4+c] = 1'b1;
    while (valid_cnt == v0 && lat < DB + 60) begin
      tick(1); lat++;
      if (irq_lat < 0 && !irq_n) irq_lat = lat;
    end
    check(irq_lat >= 1 && irq_lat <= 3, "R2 irq latency", irq_lat, 3);
    check(valid_cnt == v0 + 1, "R5 one code", valid_cnt - v0, 1);
    check(last_code == 4'(r*4+c), "R5 code", last_code, r*4+c);
    check(lat >= DB, "R3 debounce latency", lat, DB);
    check(irq_n == 1'b1, "R5 irq released", irq_n, 1);
    wait_rearm();
  endtask

  // R6: short blip
  task automatic test_glitch();
    int v0;
    v0 = valid_cnt; irq_seen = 0;
    pressed[5] = 1'b1; tick(4); pressed = '0;
    tick(DB + 30);
    check(irq_seen, "R6 blip woke", irq_seen, 1);
    check(valid_cnt == v0, "R6 no code", valid_cnt - v0, 0);
    check(irq_n == 1'b1 && col_out == 4'h0, "R6 idle", {irq_n, col_out}, 16);
  endtask

  // R7: two keys
  task automatic test_multi(input int a, input int b, input string tag);
    int v0;
    v0 = valid_cnt; irq_seen = 0;
    pressed[a] = 1'b1; pressed[b] = 1'b1;
    tick(DB + 40);
    check(irq_seen, {tag, " woke"}, irq_seen, 1);
    check(valid_cnt == v0, {tag, " no code"}, valid_cnt - v0, 0);
    check(irq_n == 1'b1, {tag, " irq released"}, irq_n, 1);
    wait_rearm();
  endtask

  // R8: hold and bounce
  task automatic test_hold_bounce();
    int v0;
    v0 = valid_cnt;
    pressed[10] = 1'b1; tick(3*DB + 50);
    check(valid_cnt == v0 + 1, "R8 held key once", valid_cnt - v0, 1);
    pressed = '0; tick(DB/2);
    pressed[10] = 1'b1; tick(10);
    pressed = '0; tick(DB/2);
    pressed[10] = 1'b1; tick(DB + 40);
    check(valid_cnt == v0 + 1, "R8 bounce ignored", valid_cnt - v0, 1);
    wait_rearm();
    test_single(0, 3);
  endtask

  // R9: reset during scan
  task automatic test_reset_mid();
    int v0;
    pressed[15] = 1'b1; tick(DB + 5);
    check(irq_n == 1'b0, "R9 in scan", irq_n, 0);
    rst = 1'b1; pressed = '0; tick(1); rst = 1'b0;
    tick(1);
    check(col_out == 4'h0 && irq_n && !key_valid, "R9 reset idle",
          {col_out, irq_n, key_valid}, 2);
    v0 = valid_cnt;
    tick(DB + 30);
    check(valid_cnt == v0, "R9 no code after reset", valid_cnt - v0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4); rst = 1'b0; tick(1);
    // R1
    check(col_out == 4'h0 && irq_n && !key_valid, "R1 reset state",
          {col_out, irq_n, key_valid}, 2);
    for (int r = 0; r < 4; r++)
      for (int c = 0; c < 4; c++)
        test_single(r, c);
    test_glitch();
    test_multi(0, 1, "R7 same row");
    test_multi(2, 6, "R7 same col");
    test_multi(4, 11, "R7 diagonal");
    test_hold_bounce();
    test_reset_mid();
    test_single(2, 1);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

endmodule